// File: doc/BRIEF.md
# Fuse PROM programming sequencer

This block burns a 256-word by 4-bit image into a one-time fuse memory. The image is first loaded into an internal buffer through a simple write port. On a start request the sequencer walks the device addresses in ascending order. A blank device reads as all ones, so only the image bits that are 0 need work. Each such bit gets its own timed sequence: the address is held, program-enable is raised, a settle interval passes, and then the data lane for that bit is pulsed for a fixed number of cycles before everything is released.

Once all the 0 bits of a word have been handled, the word is read back from the device and compared with the image. A mismatch in either direction ends the run. This covers a fuse that did not blow and a fuse that was already blown. On a mismatch the error flag is raised and the failing address is held. A run that gets through every word ends with a one-cycle done pulse. Generating the programming voltages and shaping the analog pulse are handled outside this block.

Top module: `fuse_prog_seq`

## Requirements
- R1: A write on the image port (`img_we` high) stores `img_wdata` at `img_waddr` while the sequencer is idle. A write presented while `busy` is high is discarded.
- R2: Image bit value 0 means "blow this fuse". Every 0 bit produces exactly one lane pulse. Every 1 bit produces none. At most one bit of `dev_lane_pulse` is high in any cycle, and bit n of that bus targets data bit n of the word.
- R3: A lane pulse is only driven while `dev_pgm_en` is high. Program-enable stays high for SETTLE_CYC cycles before the pulse starts. The pulse lasts PULSE_CYC cycles. Program-enable drops in the first cycle after the pulse ends.
- R4: `dev_addr` does not change while `dev_pgm_en` is high.
- R5: Words are handled in ascending address order starting at 0. Each step moves the address up by one. Within a word, lanes are pulsed from lane 0 towards lane 3.
- R6: Between two rises of `dev_pgm_en`, program-enable stays low for at least GAP_CYC cycles.
- R7: After each word, `dev_rd` is raised and the word returned on `dev_rdata` is compared with the image. Any differing bit raises `err`, sets `err_addr` to that word's address, and ends the run. No further pulses follow. The flag clears when the next run starts.
- R8: A run that completes without a mismatch raises `done` for exactly one cycle, in the same cycle that `busy` falls.
- R9: A `start` request that arrives while `busy` is high has no effect. The run continues without restarting its address walk.
- R10: After reset, `busy`, `done`, `err`, `dev_pgm_en`, `dev_rd` and `dev_lane_pulse` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| img_we | input | 1 | Image buffer write strobe |
| img_waddr | input | ADDR_W | Image buffer write address |
| img_wdata | input | LANES | Image word to store (0 bit = blow) |
| start | input | 1 | Begin a programming run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at successful end of run |
| err | output | 1 | Read-back mismatch seen in the last run |
| err_addr | output | ADDR_W | Address of the failing word |
| dev_addr | output | ADDR_W | Address applied to the fuse device |
| dev_pgm_en | output | 1 | Program-enable to the device |
| dev_lane_pulse | output | LANES | Per-lane blow pulse |
| dev_rd | output | 1 | Read-back strobe |
| dev_rdata | input | LANES | Word read back from the device |

## Verification
The hardest condition to reach from the ports is a read-back mismatch. With a well-behaved device every pulse blows its fuse, so the comparison always matches. The bench models the fuse array itself and can be told to ignore the pulses for one fuse, leaving it stuck at 1, or to start with one fuse already blown where the image wants a 1. Both cases make the device's behaviour the only source of the error, so the check on the stopping address and on the untouched later words depends only on the sequencer's reaction.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_GAP,
        ST_SETTLE,
        ST_PULSE,
        ST_READ,
        ST_CHECK
    } seq_state_e;

endpackage

// File: rtl/fps_image_buf.sv
module fps_image_buf #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LANES-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANES-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/fps_timer.sv
module fps_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/fps_lane_sel.sv
module fps_lane_sel #(
    parameter int LANES  = 4,
    parameter int LIDX_W = 3
) (
    input  logic [LANES-1:0]  word,
    input  logic [LIDX_W-1:0] from_lane,
    output logic              found,
    output logic [LIDX_W-1:0] lane
);
    logic [LANES-1:0] cand;

    for (genvar g = 0; g < LANES; g++) begin : g_cand
        assign cand[g] = !word[g] && (LIDX_W'(g) >= from_lane);
    end

    always_comb begin
        found = 1'b0;
        lane  = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                lane  = LIDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq #(
    parameter int ADDR_W     = 8,
    parameter int LANES      = 4,
    parameter int SETTLE_CYC = 16,
    parameter int PULSE_CYC  = 4,
    parameter int GAP_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              img_we,
    input  logic [ADDR_W-1:0] img_waddr,
    input  logic [LANES-1:0]  img_wdata,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] err_addr,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              dev_pgm_en,
    output logic [LANES-1:0]  dev_lane_pulse,
    output logic              dev_rd,
    input  logic [LANES-1:0]  dev_rdata
);
    import fps_pkg::*;

    localparam int DEPTH    = 1 << ADDR_W;
    localparam int LIDX_W   = $clog2(LANES) + 1;
    localparam int MAX_SP   = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
    localparam int MAX_CYC  = (MAX_SP > GAP_CYC) ? MAX_SP : GAP_CYC;
    localparam int TMR_W    = $clog2(MAX_CYC + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [LIDX_W-1:0] lane;
        logic              done;
        logic              err;
        logic [ADDR_W-1:0] err_addr;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic [LANES-1:0]  img_word;
    logic              zero_found;
    logic [LIDX_W-1:0] zero_lane;
    logic              buf_wr_en;

    assign buf_wr_en = img_we && (r_q.st == ST_IDLE);

    fps_image_buf #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_image_buf (
        .clk   (clk),
        .wr_en (buf_wr_en),
        .waddr (img_waddr),
        .wdata (img_wdata),
        .raddr (r_q.addr),
        .rdata (img_word)
    );

    fps_timer #(
        .CNT_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    fps_lane_sel #(
        .LANES  (LANES),
        .LIDX_W (LIDX_W)
    ) u_lane_sel (
        .word      (img_word),
        .from_lane (r_q.lane),
        .found     (zero_found),
        .lane      (zero_lane)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_SCAN;
                    r_d.addr = '0;
                    r_d.lane = '0;
                    r_d.err  = 1'b0;
                end
            end
            ST_SCAN: begin
                if (zero_found) begin
                    r_d.lane = zero_lane;
                    r_d.st   = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(GAP_CYC - 1);
                end else begin
                    r_d.st = ST_READ;
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    r_d.st   = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(SETTLE_CYC - 1);
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    r_d.st   = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(PULSE_CYC - 1);
                end
            end
            ST_PULSE: begin
                if (tmr_expired) begin
                    r_d.lane = r_q.lane + 1'b1;
                    r_d.st   = ST_SCAN;
                end
            end
            ST_READ: begin
                r_d.st = ST_CHECK;
            end
            ST_CHECK: begin
                if (dev_rdata != img_word) begin
                    r_d.err      = 1'b1;
                    r_d.err_addr = r_q.addr;
                    r_d.st       = ST_IDLE;
                end else if (r_q.addr == LAST_ADDR) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.addr = r_q.addr + 1'b1;
                    r_d.lane = '0;
                    r_d.st   = ST_SCAN;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, lane: '0, done: 1'b0,
                     err: 1'b0, err_addr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign done       = r_q.done;
    assign err        = r_q.err;
    assign err_addr   = r_q.err_addr;
    assign dev_addr   = r_q.addr;
    assign dev_pgm_en = (r_q.st == ST_SETTLE) || (r_q.st == ST_PULSE);
    assign dev_rd     = (r_q.st == ST_READ) || (r_q.st == ST_CHECK);

    for (genvar g = 0; g < LANES; g++) begin : g_pulse
        assign dev_lane_pulse[g] = (r_q.st == ST_PULSE) && (r_q.lane == LIDX_W'(g));
    end

endmodule

// File: rtl/fuse_prog_seq_chk.sv
module fuse_prog_seq_chk #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] dev_addr,
    input logic              dev_pgm_en,
    input logic [LANES-1:0]  dev_lane_pulse,
    input logic              dev_rd
);

    AST_PULSE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_lane_pulse)); // R2

    AST_PULSE_UNDER_PGM: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_lane_pulse) |-> dev_pgm_en); // R3

    AST_PULSE_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|dev_lane_pulse) |-> !dev_pgm_en); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dev_pgm_en |-> $stable(dev_addr)); // R4

    AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_addr != $past(dev_addr)) |->
            ((dev_addr == ADDR_W'($past(dev_addr) + 1'b1)) || (dev_addr == '0))); // R5

    AST_PGM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_pgm_en) |-> !$past(dev_pgm_en, 2)); // R6

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !dev_pgm_en)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !err)); // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !dev_rd) |=> (busy && $stable(dev_addr))); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!dev_pgm_en && !dev_rd && (dev_lane_pulse == '0))); // R10

endmodule

bind fuse_prog_seq fuse_prog_seq_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .busy           (busy),
    .done           (done),
    .err            (err),
    .dev_addr       (dev_addr),
    .dev_pgm_en     (dev_pgm_en),
    .dev_lane_pulse (dev_lane_pulse),
    .dev_rd         (dev_rd)
);

// File: tb/fuse_prog_seq_bench.sv
module fuse_prog_seq_bench;
    localparam int ADDR_W = 8;
    localparam int LANES  = 4;
    localparam int SETTLE = 16;
    localparam int PULSE  = 4;
    localparam int GAP    = 2;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              img_we = 1'b0;
    logic [ADDR_W-1:0] img_waddr = '0;
    logic [LANES-1:0]  img_wdata = '0;
    logic              start = 1'b0;
    logic              busy, done, err, dev_pgm_en, dev_rd;
    logic [ADDR_W-1:0] err_addr, dev_addr;
    logic [LANES-1:0]  dev_lane_pulse, dev_rdata;

    always #2.5 clk = ~clk;

    fuse_prog_seq #(
        .ADDR_W (ADDR_W), .LANES (LANES), .SETTLE_CYC (SETTLE),
        .PULSE_CYC (PULSE), .GAP_CYC (GAP)
    ) u_fuse_prog_seq (
        .clk (clk), .rst_n (rst_n), .img_we (img_we), .img_waddr (img_waddr),
        .img_wdata (img_wdata), .start (start), .busy (busy), .done (done),
        .err (err), .err_addr (err_addr), .dev_addr (dev_addr),
        .dev_pgm_en (dev_pgm_en), .dev_lane_pulse (dev_lane_pulse),
        .dev_rd (dev_rd), .dev_rdata (dev_rdata)
    );

    // image shadow and device control, written by the main process only
    logic [LANES-1:0]  img_shadow [DEPTH];
    logic [LANES-1:0]  fill_val = '1;
    logic              pre_en = 1'b0;
    logic [ADDR_W-1:0] pre_addr = '0;
    logic [LANES-1:0]  pre_val = '1;
    logic              stuck_en = 1'b0;
    logic [ADDR_W-1:0] stuck_addr = '0;
    int                stuck_lane = 0;
    logic              fill_tog = 1'b0;

    // device model and protocol monitor state, written by the monitor only
    logic [LANES-1:0]  fuse_mem [DEPTH];
    logic              fill_ack = 1'b0;
    int mon_chk = 0, mon_fail = 0;
    int pulse_total = 0, done_seen = 0;
    int pgm_run = 0, low_run = 100, pulse_run = 0;
    int last_addr = -1, last_lane = -1;
    logic prev_pgm = 1'b0, prev_busy = 1'b0, addr_moved = 1'b0;
    logic [LANES-1:0]  prev_pulse = '0;
    logic [ADDR_W-1:0] prev_addr = '0;

    int nchk = 0, nfail = 0;

    assign dev_rdata = dev_rd ? fuse_mem[dev_addr] : '0;

    task automatic mchk(input bit ok, input string req, input int act, input int expv);
        mon_chk++;
        if (!ok) begin
            mon_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (fill_tog != fill_ack) begin
            for (int a = 0; a < DEPTH; a++) fuse_mem[a] = fill_val;
            if (pre_en) fuse_mem[pre_addr] = pre_val;
            fill_ack = fill_tog;
        end
        if (rst_n) begin
            if (busy && !prev_busy) begin
                last_addr = -1; last_lane = -1; pulse_total = 0; done_seen = 0;
            end
            if (done) done_seen++;
            if (dev_pgm_en && !prev_pgm) begin
                mchk(low_run >= GAP, "R6 program-enable gap", low_run, GAP);
                addr_moved = 1'b0;
            end
            if (dev_pgm_en && prev_pgm && dev_addr != prev_addr) addr_moved = 1'b1;
            if (!dev_pgm_en && prev_pgm)
                mchk(!addr_moved, "R4 address moved under program-enable", int'(addr_moved), 0);
            low_run = dev_pgm_en ? 0 : low_run + 1;
            pgm_run = dev_pgm_en ? pgm_run + 1 : 0;
            if ((|dev_lane_pulse) && !(|prev_pulse)) begin
                int ln;
                ln = -1;
                for (int i = 0; i < LANES; i++) if (dev_lane_pulse[i]) ln = i;
                mchk(pgm_run == SETTLE + 1, "R3 settle before pulse", pgm_run - 1, SETTLE);
                mchk(img_shadow[dev_addr][ln] == 1'b0, "R2 pulse on a 1 bit", int'(dev_addr), ln);
                mchk((int'(dev_addr) > last_addr) ||
                     (int'(dev_addr) == last_addr && ln > last_lane),
                     "R5 pulse order", int'(dev_addr) * 4 + ln, last_addr * 4 + last_lane);
                last_addr = int'(dev_addr);
                last_lane = ln;
                pulse_total++;
                if (!(stuck_en && dev_addr == stuck_addr && ln == stuck_lane))
                    fuse_mem[dev_addr][ln] = 1'b0;
            end
            if (!(|dev_lane_pulse) && (|prev_pulse)) begin
                mchk(pulse_run == PULSE, "R3 pulse width", pulse_run, PULSE);
                mchk(!dev_pgm_en, "R3 release after pulse", int'(dev_pgm_en), 0);
            end
            pulse_run = (|dev_lane_pulse) ? pulse_run + 1 : 0;
        end
        prev_pgm   = dev_pgm_en;
        prev_busy  = busy;
        prev_pulse = dev_lane_pulse;
        prev_addr  = dev_addr;
    end

    function automatic logic [LANES-1:0] pat(input int a, input int kind);
        case (kind)
            0: return LANES'((a * 5) ^ (a >> 3));
            1: return '1;
            default: return '0;
        endcase
    endfunction

    task automatic load_image(input int kind);
        for (int a = 0; a < DEPTH; a++) begin
            img_we = 1'b1; img_waddr = ADDR_W'(a); img_wdata = pat(a, kind);
            img_shadow[a] = pat(a, kind);
            @(negedge clk);
        end
        img_we = 1'b0;
    endtask

    task automatic prep_device(input logic [LANES-1:0] val);
        fill_val = val;
        fill_tog = ~fill_tog;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int zeros_in_image();
        int z;
        z = 0;
        for (int a = 0; a < DEPTH; a++)
            for (int b = 0; b < LANES; b++) if (!img_shadow[a][b]) z++;
        return z;
    endfunction

    function automatic int device_mismatches();
        int m;
        m = 0;
        for (int a = 0; a < DEPTH; a++) if (fuse_mem[a] != img_shadow[a]) m++;
        return m;
    endfunction

    task automatic run_and_wait(input bit poke);
        int cyc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy) begin
            if (poke && cyc == 300) begin
                start = 1'b1; img_we = 1'b1; img_waddr = '1; img_wdata = ~img_shadow[DEPTH-1];
            end else begin
                start = 1'b0; img_we = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; img_we = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) img_shadow[a] = '1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err, "R10 reset flags", int'({busy, done, err}), 0);
        chk(!dev_pgm_en && !dev_rd && dev_lane_pulse == '0, "R10 reset device pins",
            int'({dev_pgm_en, dev_rd, dev_lane_pulse}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // mixed pattern, fresh device, start and write poked mid-run
        load_image(0);
        prep_device('1);
        run_and_wait(1'b1);
        chk(!err, "R7 no error on good device", int'(err), 0);
        chk(done_seen == 1, "R8 single done pulse", done_seen, 1);
        chk(pulse_total == zeros_in_image(), "R2 pulse count", pulse_total, zeros_in_image());
        chk(device_mismatches() == 0, "R1 R9 device equals image", device_mismatches(), 0);
        chk(last_addr == DEPTH - 1, "R5 walk reached last word", last_addr, DEPTH - 1);

        // image all ones: nothing to blow
        load_image(1);
        prep_device('1);
        run_and_wait(1'b0);
        chk(pulse_total == 0, "R2 no pulse for 1 bits", pulse_total, 0);
        chk(done_seen == 1 && !err, "R8 done on blank image", done_seen, 1);

        // all zeros, one fuse at word 37 lane 2 refuses to blow
        load_image(2);
        stuck_en = 1'b1; stuck_addr = 8'd37; stuck_lane = 2;
        prep_device('1);
        run_and_wait(1'b0);
        stuck_en = 1'b0;
        chk(err, "R7 error on unblown fuse", int'(err), 1);
        chk(err_addr == 8'd37, "R7 error address", int'(err_addr), 37);
        chk(done_seen == 0, "R7 no done on failure", done_seen, 0);
        chk(pulse_total == 37 * 4 + 4, "R7 run stops at failing word", pulse_total, 37 * 4 + 4);
        chk(fuse_mem[38] == 4'hF, "R7 later words untouched", int'(fuse_mem[38]), 15);

        // all ones image, device has a pre-blown fuse at word 5
        load_image(1);
        pre_en = 1'b1; pre_addr = 8'd5; pre_val = 4'b1011;
        prep_device('1);
        pre_en = 1'b0;
        run_and_wait(1'b0);
        chk(err && err_addr == 8'd5, "R7 stray zero detected", int'(err_addr), 5);
        chk(pulse_total == 0, "R2 no pulse on stray zero run", pulse_total, 0);

        // clean rerun clears the error flag
        prep_device('1);
        run_and_wait(1'b0);
        chk(!err && done_seen == 1, "R7 error cleared by new run", int'(err), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk + mon_chk, nfail + mon_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("== %0d vectors applied, %0d miscompares ==",
                 nchk + mon_chk + 1, nfail + mon_fail + 1);
        $finish;
    end

endmodule